// File: doc/BRIEF.md
# Permutation-Code LRU Way Tracker

This block keeps the least-recently-used order of the ways of a set-associative cache, one order per line index. The number of ways (1 to 4) and the number of lines are parameters. Each line's order is held as a dense code that numbers every possible ordering of the ways. Two ways need 1 bit, three ways need 3 bits and four ways need 5 bits.

An access strobe carries a line index and a way number. It moves that way to the most-recently-used end of that line's order and keeps the other ways in their relative order. A victim query carries a line index. One cycle later the block returns the least-recently-used way of that line together with the line's order code. The cache controller around the block uses the returned way as the replacement candidate on a miss.

Top module: `lru_perm_tracker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `victim_valid` is low. After reset every line holds code 0 (ways in ascending order, way 0 least recent), so a query reports victim 0 and code 0.
- R2: A query made in cycle N is reported in cycle N+1. `victim_valid` is high in that cycle only, and the results belong to `query_line`.
- R3: With 4 ways, `order_code` is the rank of the line's order among all 24 orderings in lexicographic order. An order is written from least to most recent, so 0123 is 0, 0132 is 1, 1230 is 9 and 3210 is 23.
- R4: With 3 ways, the codes are 012=0, 021=1, 102=2, 120=3, 201=4 and 210=5.
- R5: With 2 ways, the 1-bit code equals the least-recently-used way. An access to way w sets it to the other way.
- R6: An access to way w removes w from the line's order and appends it as most recent, keeping the rest in order. For example, 0123 accessed at way 2 becomes 0132, and 012 accessed at way 0 becomes 120.
- R7: The reported victim is the leftmost (least recent) way of the line's current order.
- R8: An access whose way number is not below the number of ways leaves every line unchanged.
- R9: When an access and a query name the same line in the same cycle, the query reports the order as it was before that access.
- R10: An access changes only the line it names. All other lines keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| touch_valid | input | 1 | Access strobe |
| touch_line | input | IDX_W | Line index of the access |
| touch_way | input | 2 | Way that was accessed |
| query_valid | input | 1 | Victim query strobe |
| query_line | input | IDX_W | Line index of the query |
| victim_valid | output | 1 | Query result valid, one cycle after the query |
| victim_way | output | 2 | Least-recently-used way of the queried line |
| order_code | output | CODE_W | Order code of the queried line |

## Verification
The bench drives three instances with 4, 3 and 2 ways from the same stimulus. It compares every result with a model that keeps each line's order as an explicit list of ways, so a wrong entry in the code numbering or in the reordering shows up as a mismatched code. Random traffic must visit every reachable code with every accessed way. A design that mis-ranks a single rarely reached ordering therefore cannot pass unnoticed.

Directed cases cover the following:
- An access and a query to the same line in the same cycle. A design that forwards the update returns the new order instead of the old one.
- A way number one past the last way on the 3-way instance. A design that does not filter it corrupts the order.
- Accesses to one line followed by queries to the other lines. This catches a write that reaches the wrong line.

// File: rtl/lru_perm_pkg.sv
`timescale 1ns/1ps
package lru_perm_pkg;

    localparam int MAX_WAYS = 4;
    localparam int WAY_BITS = 2;

    typedef logic [WAY_BITS-1:0] way_t;
    typedef way_t [MAX_WAYS-1:0] order_t;   // index 0 = least recent

    typedef struct packed {
        logic valid;
        way_t victim;
    } report_t;

    // Number of orderings of 'ways' ways (ways factorial).
    function automatic int perm_count(int ways);
        int p = 1;
        for (int i = 2; i <= MAX_WAYS; i++) begin
            if (i <= ways) p = p * i;
        end
        return p;
    endfunction

    function automatic int code_bits(int ways);
        return (ways <= 2) ? 1 : $clog2(perm_count(ways));
    endfunction

    // Code to ordering. Codes past the last ordering act as the last one.
    function automatic order_t perm_decode(int ways, int code);
        order_t                ord   = '0;
        logic [MAX_WAYS-1:0]   taken = '0;
        int rest, weight, pick, seen;
        rest = code;
        if (rest > perm_count(ways) - 1) rest = perm_count(ways) - 1;
        for (int pos = 0; pos < MAX_WAYS; pos++) begin
            if (pos < ways) begin
                weight = perm_count(ways - 1 - pos);
                pick   = rest / weight;
                rest   = rest % weight;
                seen   = 0;
                for (int w = 0; w < MAX_WAYS; w++) begin
                    if (w < ways && !taken[w]) begin
                        if (seen == pick) begin
                            ord[pos] = way_t'(w);
                            taken[w] = 1'b1;
                        end
                        seen++;
                    end
                end
            end
        end
        return ord;
    endfunction

    // Ordering to code: lexicographic rank.
    function automatic int perm_encode(int ways, order_t ord);
        int acc = 0;
        int smaller;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < ways) begin
                smaller = 0;
                for (int j = 0; j < MAX_WAYS; j++) begin
                    if (j > i && j < ways && ord[j] < ord[i]) smaller++;
                end
                acc = acc + smaller * perm_count(ways - 1 - i);
            end
        end
        return acc;
    endfunction

    // Move 'way' to the most-recent end, the rest keep their order.
    function automatic order_t perm_touch(int ways, order_t ord, way_t way);
        order_t res = ord;
        int k = 0;
        for (int i = 0; i < MAX_WAYS; i++) begin
            if (i < ways && ord[i] != way && k < MAX_WAYS) begin
                res[k] = ord[i];
                k++;
            end
        end
        res[ways-1] = way;
        return res;
    endfunction

    function automatic way_t perm_lru(int ways, int code);
        order_t ord = perm_decode(ways, code);
        return ord[0];
    endfunction

endpackage

// File: rtl/lru_state_array.sv
`timescale 1ns/1ps
module lru_state_array #(
    parameter int LINES  = 16,
    parameter int CODE_W = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_line,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [IDX_W-1:0]  rd_a_line,
    output logic [CODE_W-1:0] rd_a_code,
    input  logic [IDX_W-1:0]  rd_b_line,
    output logic [CODE_W-1:0] rd_b_code
);

    logic [CODE_W-1:0] codes [LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LINES; i++) begin
            if (rst) begin
                codes[i] <= '0;
            end else if (wr_en && wr_line == IDX_W'(i)) begin
                codes[i] <= wr_code;
            end
        end
    end

    assign rd_a_code = codes[rd_a_line];
    assign rd_b_code = codes[rd_b_line];

endmodule

// File: rtl/lru_perm_next.sv
`timescale 1ns/1ps
module lru_perm_next
    import lru_perm_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] cur_code,
    input  way_t              touch_way,
    output logic [CODE_W-1:0] next_code
);

    always_comb begin
        next_code = CODE_W'(perm_encode(WAYS,
                        perm_touch(WAYS, perm_decode(WAYS, int'(cur_code)), touch_way)));
    end

endmodule

// File: rtl/lru_perm_victim.sv
`timescale 1ns/1ps
module lru_perm_victim
    import lru_perm_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] cur_code,
    output way_t              victim
);

    always_comb begin
        victim = perm_lru(WAYS, int'(cur_code));
    end

endmodule

// File: rtl/lru_perm_tracker.sv
`timescale 1ns/1ps
module lru_perm_tracker
    import lru_perm_pkg::*;
#(
    parameter  int WAYS   = 4,
    parameter  int LINES  = 16,
    localparam int CODE_W = code_bits(WAYS),
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              touch_valid,
    input  logic [IDX_W-1:0]  touch_line,
    input  logic [1:0]        touch_way,
    input  logic              query_valid,
    input  logic [IDX_W-1:0]  query_line,
    output logic              victim_valid,
    output logic [1:0]        victim_way,
    output logic [CODE_W-1:0] order_code
);

    logic              touch_ok;
    logic [CODE_W-1:0] touch_cur;
    logic [CODE_W-1:0] touch_next;
    logic [CODE_W-1:0] query_cur;
    way_t              query_lru;
    report_t           rep_q;
    logic [CODE_W-1:0] code_q;

    assign touch_ok = touch_valid && (int'(touch_way) < WAYS);

    lru_state_array #(
        .LINES  (LINES),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (touch_ok),
        .wr_line   (touch_line),
        .wr_code   (touch_next),
        .rd_a_line (touch_line),
        .rd_a_code (touch_cur),
        .rd_b_line (query_line),
        .rd_b_code (query_cur)
    );

    lru_perm_next #(
        .WAYS   (WAYS),
        .CODE_W (CODE_W)
    ) u_next (
        .cur_code  (touch_cur),
        .touch_way (touch_way),
        .next_code (touch_next)
    );

    lru_perm_victim #(
        .WAYS   (WAYS),
        .CODE_W (CODE_W)
    ) u_victim (
        .cur_code (query_cur),
        .victim   (query_lru)
    );

    // The report samples the stored code before this cycle's update lands.
    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q  <= '0;
            code_q <= '0;
        end else begin
            rep_q.valid <= query_valid;
            if (query_valid) begin
                rep_q.victim <= query_lru;
                code_q       <= query_cur;
            end
        end
    end

    assign victim_valid = rep_q.valid;
    assign victim_way   = rep_q.victim;
    assign order_code   = code_q;

endmodule

// File: rtl/lru_perm_tracker_chk.sv
`timescale 1ns/1ps
module lru_perm_tracker_chk
    import lru_perm_pkg::*;
#(
    parameter  int WAYS   = 4,
    parameter  int LINES  = 16,
    localparam int CODE_W = code_bits(WAYS),
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              touch_valid,
    input logic [IDX_W-1:0]  touch_line,
    input logic [1:0]        touch_way,
    input logic              query_valid,
    input logic [IDX_W-1:0]  query_line,
    input logic              victim_valid,
    input logic [1:0]        victim_way,
    input logic [CODE_W-1:0] order_code
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !victim_valid);

    // R2
    report_latency_chk: assert property (@(posedge clk) disable iff (rst)
        query_valid |=> victim_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !query_valid |=> !victim_valid);

    // R3 R4 R5
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> (int'(order_code) < perm_count(WAYS)));

    // R7
    victim_range_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> (int'(victim_way) < WAYS));

    generate
        if (WAYS > 1) begin : g_multi
            // R6
            fresh_mru_chk: assert property (@(posedge clk) disable iff (rst)
                (query_valid && !$past(rst) && $past(touch_valid)
                 && (int'($past(touch_way)) < WAYS)
                 && query_line == $past(touch_line))
                |=> victim_way != $past(touch_way, 2));
        end
    endgenerate

endmodule

bind lru_perm_tracker lru_perm_tracker_chk #(.WAYS(WAYS), .LINES(LINES)) u_chk (.*);

// File: tb/lru_perm_tracker_test.sv
`timescale 1ns/1ps
module lru_perm_tracker_test;

    localparam int LN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tv = 1'b0, qv = 1'b0;
    logic [1:0] tl = '0, ql = '0, tw = '0;

    logic       vv4, vv3, vv2;
    logic [1:0] vw4, vw3, vw2;
    logic [4:0] oc4;
    logic [2:0] oc3;
    logic [0:0] oc2;

    always #4 clk = ~clk;

    lru_perm_tracker #(.WAYS(4), .LINES(LN)) uut (
        .clk(clk), .rst(rst), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
        .query_valid(qv), .query_line(ql),
        .victim_valid(vv4), .victim_way(vw4), .order_code(oc4));

    lru_perm_tracker #(.WAYS(3), .LINES(LN)) uut_w3 (
        .clk(clk), .rst(rst), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
        .query_valid(qv), .query_line(ql),
        .victim_valid(vv3), .victim_way(vw3), .order_code(oc3));

    lru_perm_tracker #(.WAYS(2), .LINES(LN)) uut_w2 (
        .clk(clk), .rst(rst), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
        .query_valid(qv), .query_line(ql),
        .victim_valid(vv2), .victim_way(vw2), .order_code(oc2));

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int cyc     = 0;

    int nw [3] = '{4, 3, 2};
    int mdl [3][LN][4];          // explicit order per line, index 0 = least recent
    int cov [3][24][4];

    typedef struct {
        int    code [3];
        int    vict [3];
        int    cyc;
        string req;
    } exp_t;

    exp_t sb [$];
    exp_t got;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int m_rank(int k, int l);
        int acc = 0;
        int f;
        int sm;
        for (int i = 0; i < nw[k]; i++) begin
            sm = 0;
            for (int j = i + 1; j < nw[k]; j++) if (mdl[k][l][j] < mdl[k][l][i]) sm++;
            f = 1;
            for (int m = 2; m <= nw[k] - 1 - i; m++) f = f * m;
            acc = acc + sm * f;
        end
        return acc;
    endfunction

    task automatic m_touch(int k, int l, int w);
        int tmp [4];
        int n = 0;
        for (int i = 0; i < nw[k]; i++) begin
            if (mdl[k][l][i] != w) begin
                tmp[n] = mdl[k][l][i];
                n++;
            end
        end
        tmp[nw[k]-1] = w;
        for (int i = 0; i < nw[k]; i++) mdl[k][l][i] = tmp[i];
    endtask

    // Driver: one cycle of stimulus, expected results pushed to the scoreboard.
    task automatic step(bit t_v, int t_l, int t_w, bit q_v, int q_l, string req);
        exp_t e;
        @(negedge clk);
        tv = t_v; tl = 2'(t_l); tw = 2'(t_w);
        qv = q_v; ql = 2'(q_l);
        if (q_v) begin
            for (int k = 0; k < 3; k++) begin
                e.code[k] = m_rank(k, q_l);
                e.vict[k] = mdl[k][q_l][0];
            end
            e.cyc = cyc;
            e.req = req;
            sb.push_back(e);
        end
        if (t_v) begin
            for (int k = 0; k < 3; k++) begin
                if (t_w < nw[k]) begin
                    cov[k][m_rank(k, t_l)][t_w] = 1;
                    m_touch(k, t_l, t_w);
                end
            end
        end
    endtask

    // Monitor: pops and compares whenever results appear.
    always @(negedge clk) begin
        if (rst) begin
            chk("R1 valid low in reset", int'(vv4 | vv3 | vv2), 0);
        end else if (vv4 || vv3 || vv2) begin
            chk("R2 instances agree on valid", int'(vv4 & vv3 & vv2), 1);
            if (sb.size() == 0) begin
                chk("R2 unexpected result", 1, 0);
            end else begin
                got = sb.pop_front();
                chk({got.req, " R2 latency"}, cyc, got.cyc + 1);
                chk({got.req, " R3 code 4-way"}, int'(oc4), got.code[0]);
                chk({got.req, " R4 code 3-way"}, int'(oc3), got.code[1]);
                chk({got.req, " R5 code 2-way"}, int'(oc2), got.code[2]);
                chk({got.req, " R7 victim 4-way"}, int'(vw4), got.vict[0]);
                chk({got.req, " R7 victim 3-way"}, int'(vw3), got.vict[1]);
                chk({got.req, " R7 victim 2-way"}, int'(vw2), got.vict[2]);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int need, seen;
        for (int k = 0; k < 3; k++)
            for (int l = 0; l < LN; l++)
                for (int i = 0; i < 4; i++) mdl[k][l][i] = i;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every line
        for (int l = 0; l < LN; l++) step(0, 0, 0, 1, l, "R1 reset line");

        // R3 R6: 0123 touched at way 2 -> 0132 (code 1)
        step(1, 0, 2, 0, 0, "");
        step(0, 0, 0, 1, 0, "R3 R6 touch way2");
        // R4: 012 touched at way 0 -> 120 (code 3)
        step(1, 1, 0, 0, 0, "");
        step(0, 0, 0, 1, 1, "R4 R6 touch way0");
        // R10: other lines untouched
        step(0, 0, 0, 1, 2, "R10 line2 unchanged");
        step(0, 0, 0, 1, 3, "R10 line3 unchanged");
        // R5: 2-way access to way 0 makes way 1 LRU
        step(1, 2, 0, 0, 0, "");
        step(0, 0, 0, 1, 2, "R5 two-way bit");
        // R8: way 3 on the 3-way and 2-way instances is ignored
        step(1, 3, 3, 0, 0, "");
        step(0, 0, 0, 1, 3, "R8 out-of-range way");
        // R9: access and query to the same line in one cycle
        step(1, 0, 0, 1, 0, "R9 same-cycle old order");
        step(0, 0, 0, 1, 0, "R9 update visible next");

        // Random traffic with collisions
        for (int n = 0; n < 3000; n++) begin
            step(1, $urandom_range(0, LN - 1), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), $urandom_range(0, LN - 1), "R6 R7 random");
        end
        step(0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, "");

        // Every reachable code met with every accessed way
        for (int k = 0; k < 3; k++) begin
            need = (k == 0) ? 96 : (k == 1) ? 18 : 4;
            seen = 0;
            for (int c = 0; c < 24; c++)
                for (int w = 0; w < 4; w++) seen += cov[k][c][w];
            chk("R6 transition coverage", seen, need);
        end
        chk("R2 scoreboard drained", sb.size(), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule